// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block predicts the direction of conditional branches. It keeps a table of 2-bit saturating counters. A fetch-side PC selects one counter through a combinational lookup, and the counter's upper bit gives the guess: taken or not taken. When a branch resolves, the back end presents a resolve strobe together with the branch PC and the actual outcome.

In the cycle of the strobe, the block compares the outcome with the counter's current guess. It flags a mispredict and reports a fixed penalty of two cycles. At the clock edge that carries the strobe, it moves the counter one step toward the outcome.

Instructions are halfword aligned, so PC bit 0 never takes part in the table index. A taken branch also raises a one-cycle jump marker in the following cycle, for use by a downstream hazard tracker. Target addresses are not predicted.

Top module: `bimodal_pred`

## Requirements
- R1: After reset every counter is 0 (strongly not taken), so the prediction is not taken for every PC; jump_mark is 0.
- R2: A PC selects the entry (PC & (SPAN-1)) >> 1, which is bits [4:1] for the default SPAN of 32. PCs that differ only in bit 0 or in bits 5 and above share an entry.
- R3: lk_pred is 1 exactly when bit 1 of the counter selected by lk_pc is set, that is when the counter value is 2 or 3.
- R4: While rs_valid is high, rs_mispredict is 1 when rs_taken differs from the prediction of the entry selected by rs_pc. rs_penalty is then 2, and otherwise 0. With rs_valid low, both outputs are 0.
- R5: A taken resolve increments the selected counter at the clock edge, and a counter at 3 stays at 3.
- R6: A not-taken resolve decrements the selected counter at the clock edge, and a counter at 0 stays at 0.
- R7: jump_mark is 1 for exactly the cycle after an edge that carried a taken resolve, and 0 after every other edge.
- R8: With rs_valid low no counter changes, whatever rs_pc and rs_taken are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC for the direction lookup |
| lk_pred | output | 1 | Predicted direction, 1 means taken |
| rs_valid | input | 1 | Branch resolve strobe |
| rs_pc | input | 32 | PC of the resolving branch |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_mispredict | output | 1 | Outcome differed from the prediction |
| rs_penalty | output | 2 | Penalty cycles for this resolve (0 or 2) |
| jump_mark | output | 1 | A taken branch resolved on the previous edge |

## Verification
The hardest states to reach from the ports are the counter sitting at a saturation limit while the opposite outcome arrives, and two PCs aliasing onto one entry. The stimulus table drives a single entry four times taken so that it saturates at 3. It then resolves an aliased PC (bit 0 set, bit 5 set) as not taken, which must read that saturated counter and mispredict. Counter values are never visible directly, so each one is inferred from the prediction and mispredict flag of the following resolve. The idle check relies on the same inference after several strobe-free cycles with rs_taken held high.

// File: rtl/bimodal_pred.sv
module bimodal_pred #(
  parameter int PC_W     = 32,
  parameter int SPAN     = 32,
  parameter int CTR_W    = 2,
  parameter int MISS_CYC = 2,
  parameter int PEN_W    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  output logic            rs_mispredict,
  output logic [PEN_W-1:0] rs_penalty,
  output logic            jump_mark
);
  localparam int DEPTH = SPAN / 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] ctr [DEPTH];
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [CTR_W-1:0] rs_ctr;
  logic             rs_guess;

  assign lk_idx   = lk_pc[IDX_W:1];
  assign rs_idx   = rs_pc[IDX_W:1];
  assign lk_pred  = ctr[lk_idx][CTR_W-1];
  assign rs_ctr   = ctr[rs_idx];
  assign rs_guess = rs_ctr[CTR_W-1];

  assign rs_mispredict = rs_valid && (rs_taken != rs_guess);
  assign rs_penalty    = rs_mispredict ? PEN_W'(MISS_CYC) : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctr[i] <= '0;
      else if (rs_valid && rs_idx == IDX_W'(i)) begin
        if (rs_taken && ctr[i] != CTR_MAX)
          ctr[i] <= ctr[i] + 1'b1;
        else if (!rs_taken && ctr[i] != '0)
          ctr[i] <= ctr[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jump_mark <= 1'b0;
    else        jump_mark <= rs_valid && rs_taken;
  end
endmodule

// File: rtl/bimodal_pred_chk.sv
module bimodal_pred_chk #(
  parameter int CTR_W = 2,
  parameter int PEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rs_valid,
  input logic             rs_taken,
  input logic             rs_mispredict,
  input logic [PEN_W-1:0] rs_penalty,
  input logic             jump_mark,
  input logic [CTR_W-1:0] rs_ctr
);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (!rs_mispredict && rs_penalty == '0));

  a_r4_miss_costs_two: assert property (@(posedge clk) disable iff (!rst_n)
    rs_mispredict |-> (rs_penalty == PEN_W'(2)));

  a_r5_sat_high_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && rs_ctr == {CTR_W{1'b1}}) |-> !rs_mispredict);

  a_r6_sat_low_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && rs_ctr == '0) |-> !rs_mispredict);

  a_r7_mark_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken) |=> jump_mark);

  a_r7_mark_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_valid && rs_taken) |=> !jump_mark);
endmodule

bind bimodal_pred bimodal_pred_chk #(.CTR_W(CTR_W), .PEN_W(PEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rs_valid(rs_valid), .rs_taken(rs_taken),
  .rs_mispredict(rs_mispredict), .rs_penalty(rs_penalty),
  .jump_mark(jump_mark), .rs_ctr(rs_ctr)
);

// File: tb/tb_bimodal_pred.sv
module tb_bimodal_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_pred;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        rs_mispredict;
  logic [1:0]  rs_penalty;
  logic        jump_mark;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bimodal_pred dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_mispredict(rs_mispredict), .rs_penalty(rs_penalty),
    .jump_mark(jump_mark)
  );

  // {pc, taken, expected prediction, expected mispredict}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {32'h100, 1'b1, 1'b0, 1'b1},  // R5 0->1
    {32'h100, 1'b1, 1'b0, 1'b1},  // R5 1->2
    {32'h100, 1'b1, 1'b1, 1'b0},  // R3 R5 2->3
    {32'h100, 1'b1, 1'b1, 1'b0},  // R5 saturate at 3
    {32'h121, 1'b0, 1'b1, 1'b1},  // R2 alias of 0x100, 3->2
    {32'h102, 1'b0, 1'b0, 1'b0},  // R6 saturate at 0
    {32'h102, 1'b1, 1'b0, 1'b1},  // R4 0->1
    {32'h100, 1'b0, 1'b1, 1'b1},  // R6 2->1
    {32'h100, 1'b0, 1'b0, 1'b0},  // R6 1->0
    {32'h100, 1'b0, 1'b0, 1'b0},  // R6 stays 0
    {32'h102, 1'b1, 1'b0, 1'b1},  // R5 1->2
    {32'h102, 1'b0, 1'b1, 1'b1}   // R6 2->1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic vld,
                         input logic exp_pred, input logic exp_mis, input string req);
    @(negedge clk);
    rs_valid = vld; rs_pc = pc; rs_taken = tk; lk_pc = pc;
    #1;
    check({req, " R3 lk_pred"}, 32'(lk_pred), 32'(exp_pred));
    check({req, " R4 mispredict"}, 32'(rs_mispredict), 32'(exp_mis));
    check({req, " R4 penalty"}, 32'(rs_penalty), exp_mis ? 32'd2 : 32'd0);
    @(posedge clk); #1;
    check({req, " R7 jump_mark"}, 32'(jump_mark), 32'(vld && tk));
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    lk_pc = 32'h100; #1;
    check("R1 reset pred 0x100", 32'(lk_pred), 0);
    lk_pc = 32'h1E; #1;
    check("R1 reset pred 0x1e", 32'(lk_pred), 0);
    check("R1 reset jump_mark", 32'(jump_mark), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 jump_mark after release", 32'(jump_mark), 0);

    for (int i = 0; i < NV; i++)
      resolve(VEC[i][34:3], VEC[i][2], 1'b1, VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));

    // R8: idle cycles with rs_taken high leave entry 0x102 at 1
    for (int k = 0; k < 4; k++)
      resolve(32'h102, 1'b1, 1'b0, 1'b0, 1'b0, "R8 idle");
    resolve(32'h102, 1'b1, 1'b1, 1'b0, 1'b1, "R8 after idle 1->2");
    resolve(32'h102, 1'b1, 1'b1, 1'b1, 1'b0, "R5 2->3");

    // R2: upper PC bits alias (0x3E2 -> idx 1), entry now 3
    resolve(32'h3E2, 1'b0, 1'b1, 1'b1, 1'b1, "R2 high alias");

    // R1: reset clears a trained entry
    @(negedge clk);
    rs_valid = 1'b0; rst_n = 1'b0; #1;
    lk_pc = 32'h102; #1;
    check("R1 re-reset pred", 32'(lk_pred), 0);
    check("R1 re-reset jump_mark", 32'(jump_mark), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule